// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the front end of a small processor. It keeps a program counter, an address staging register, a data staging register and an instruction holding register. It moves an instruction from memory into the instruction register through a fixed chain of register transfers. Every memory access goes through the two staging registers: the address register drives the memory address pins and the data register drives the write data pins. Reads and writes share one memory port.

A one-cycle pulse on `fetch_go` starts a fetch, which always takes three busy cycles. In the first, the program counter is copied into the address register. In the second, the read strobe is raised and the returned word is captured into the data register. In the third, the data register is moved into the instruction register and the program counter steps to the next word. A caller can also store a data word. It holds `wr_req` with an address and a value until `wr_done` is seen, and the block then places them in the staging registers and raises the write strobe for one cycle. The memory must present `mem_rdata` for the current `mem_addr` in time to be sampled at the edge that closes the read strobe cycle.

Top module: `fetch_seq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, the address register (seen on `mem_addr`), the data register (seen on `mem_wdata`) and the instruction register become zero. After that edge `busy`, `mem_rd`, `mem_wr`, `fetch_done` and `wr_done` are all low.
- R2: The address presented during the read strobe equals the program counter value that was held when the fetch was accepted.
- R3: Each fetch raises `mem_rd` for exactly one cycle, the second cycle after the accepting edge. `mem_rd` is low in the first busy cycle and in the third.
- R4: The edge that ends the third busy cycle loads the instruction register with the memory word at the fetched address. `fetch_done` is high for exactly the one cycle that follows that edge. With the program counter at 50, the word at address 50 ends in `ir_out`.
- R5: The program counter advances by one on the same edge that loads the instruction register, and it holds its value in every other cycle. It wraps from all ones to zero.
- R6: An accepted write raises `mem_wr` and `wr_done` for one cycle, the second cycle after the accepting edge. In that cycle `mem_addr` equals `wr_addr` and `mem_wdata` equals `wr_data`. A write leaves the program counter unchanged.
- R7: `mem_rd` and `mem_wr` are never high in the same cycle.
- R8: A write request that is raised while a fetch is in progress is accepted only at the first idle edge, which is the edge that ends the `fetch_done` cycle. If `fetch_go` and `wr_req` are both high in an idle cycle, the fetch is taken first and the write follows in the same way.
- R9: `fetch_go` has no effect while `busy` is high: holding it high through a fetch produces a single read strobe and a single increment.
- R10: `busy` is high in exactly the three cycles of a fetch and the two cycles of a write, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_go | input | 1 | Start a fetch when idle |
| wr_req | input | 1 | Data write request, held until `wr_done` |
| wr_addr | input | AW | Target address of the data write |
| wr_data | input | DW | Word to store |
| mem_addr | output | AW | Memory address, driven by the address register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data, driven by the data register |
| mem_rdata | input | DW | Read data, sampled at the end of the read strobe cycle |
| ir_out | output | DW | Instruction register |
| pc_out | output | AW | Program counter |
| fetch_done | output | 1 | One-cycle pulse after the instruction register loads |
| wr_done | output | 1 | High during the write strobe cycle |
| busy | output | 1 | Sequencer not idle |

## Verification
On every cycle the assertions check the strobe exclusion, the single-cycle width of both strobes, the fixed distance from the read strobe to `fetch_done`, the gap that keeps a write away from a finished read, the copy from program counter to address register, the copy from data register to instruction register, and the rule that the program counter steps only on the load edge. The bench scenarios are needed to show end-to-end results that depend on memory contents and on the caller's timing. These are the correct word reaching `ir_out` (including the case at address 50), a write landing at the right address, the order of a write raised during a fetch or together with `fetch_go`, `fetch_go` being ignored while busy, and the counter wrapping to zero.

// File: rtl/fetch_seq_pkg.sv
`timescale 1ns/1ps
// Package: fetch_seq_pkg
// Shared state encoding and control word for the fetch sequencer.
// Assumes: one control word per cycle, decoded from the current state only.
package fetch_seq_pkg;

    typedef enum logic [2:0] {
        FS_IDLE      = 3'd0,
        FS_LOAD_MAR  = 3'd1,
        FS_READ      = 3'd2,
        FS_MOVE_IR   = 3'd3,
        FS_WR_SETUP  = 3'd4,
        FS_WR_STROBE = 3'd5
    } fs_state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_wr;
        logic mbr_from_mem;
        logic mbr_from_wr;
        logic ir_load;
        logic pc_inc;
        logic rd_strobe;
        logic wr_strobe;
    } fs_ctl_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
`timescale 1ns/1ps
// Module: fetch_seq_ctrl
// Sequences the fetch steps (address load, read, move to IR) and the
// two-step data write. It issues one control word per cycle.
// Assumes: fetch_go and wr_req are sampled only in the idle state, and
// fetch_go wins when both are high.
module fetch_seq_ctrl
    import fetch_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fetch_go,
    input  logic    wr_req,
    output fs_ctl_t ctl_o,
    output logic    busy_o,
    output logic    fetch_done_o,
    output logic    wr_done_o
);

    fs_state_e state_q;
    fs_state_e state_d;
    logic      done_q;

    // Next-state selection for the fetch and write sequences.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (fetch_go) begin
                    state_d = FS_LOAD_MAR;
                end else if (wr_req) begin
                    state_d = FS_WR_SETUP;
                end
            end
            FS_LOAD_MAR:  state_d = FS_READ;
            FS_READ:      state_d = FS_MOVE_IR;
            FS_MOVE_IR:   state_d = FS_IDLE;
            FS_WR_SETUP:  state_d = FS_WR_STROBE;
            FS_WR_STROBE: state_d = FS_IDLE;
            default:      state_d = FS_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Control word decode: each state enables only its own transfer.
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            FS_LOAD_MAR: ctl_o.mar_from_pc = 1'b1;
            FS_READ: begin
                ctl_o.rd_strobe    = 1'b1;
                ctl_o.mbr_from_mem = 1'b1;
            end
            FS_MOVE_IR: begin
                ctl_o.ir_load = 1'b1;
                ctl_o.pc_inc  = 1'b1;
            end
            FS_WR_SETUP: begin
                ctl_o.mar_from_wr = 1'b1;
                ctl_o.mbr_from_wr = 1'b1;
            end
            FS_WR_STROBE: ctl_o.wr_strobe = 1'b1;
            default: ctl_o = '0;
        endcase
    end

    // Completion pulse, high in the cycle after the IR load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == FS_MOVE_IR);
        end
    end

    assign busy_o       = (state_q != FS_IDLE);
    assign fetch_done_o = done_q;
    assign wr_done_o    = (state_q == FS_WR_STROBE);

    // R7: the two strobes never overlap.
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_o.rd_strobe && ctl_o.wr_strobe));

    // R3: the read strobe lasts a single cycle.
    p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.rd_strobe |=> !ctl_o.rd_strobe);

    // R4: the done pulse comes two cycles after the read strobe.
    p_done_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.rd_strobe |-> ##2 fetch_done_o);

    // R4: the done pulse lasts a single cycle.
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done_o |=> !fetch_done_o);

    // R6: the write strobe lasts a single cycle.
    p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.wr_strobe |=> !ctl_o.wr_strobe);

    // R8: no write strobe can follow a read until the fetch has retired.
    p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.rd_strobe |=> !ctl_o.wr_strobe ##1 !ctl_o.wr_strobe ##1 !ctl_o.wr_strobe);

    // R10: fetch_go in idle starts a busy cycle with no strobe yet.
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && fetch_go) |=> (busy_o && !ctl_o.rd_strobe && !ctl_o.wr_strobe));

endmodule

// File: rtl/fetch_seq_regs.sv
`timescale 1ns/1ps
// Module: fetch_seq_regs
// Holds PC, MAR, MBR and IR and applies the transfers chosen by the control word.
// Assumes: the control word never asks a register to be written from two
// sources at once, and mem_rdata is valid at the edge ending the read strobe.
module fetch_seq_regs
    import fetch_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fs_ctl_t       ctl_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] mar_o,
    output logic [DW-1:0] mbr_o,
    output logic [DW-1:0] ir_o
);

    localparam logic [AW-1:0] PC_STEP = AW'(1);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] mar_q;
    logic [DW-1:0] mbr_q;
    logic [DW-1:0] ir_q;

    // Program counter: steps by one only on the IR load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctl_i.pc_inc) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    // Address register: loaded from the PC for a fetch or from the request for a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctl_i.mar_from_pc) begin
            mar_q <= pc_q;
        end else if (ctl_i.mar_from_wr) begin
            mar_q <= wr_addr_i;
        end
    end

    // Data register: captures read data or the word to be stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (ctl_i.mbr_from_mem) begin
            mbr_q <= rdata_i;
        end else if (ctl_i.mbr_from_wr) begin
            mbr_q <= wr_data_i;
        end
    end

    // Instruction register: takes the data register on the final fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctl_i.ir_load) begin
            ir_q <= mbr_q;
        end
    end

    assign pc_o  = pc_q;
    assign mar_o = mar_q;
    assign mbr_o = mbr_q;
    assign ir_o  = ir_q;

    // R2: the address register receives the PC value.
    p_mar_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.mar_from_pc |=> (mar_q == $past(pc_q)));

    // R4: the IR receives the data register contents.
    p_ir_from_mbr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.ir_load |=> (ir_q == $past(mbr_q)));

    // R5: the PC steps by exactly one on an increment cycle.
    p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.pc_inc |=> (pc_q == $past(pc_q) + PC_STEP));

    // R5: the PC holds in every other cycle.
    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_i.pc_inc |=> $stable(pc_q));

    // R5: the PC step and the IR load happen together.
    p_pc_with_ir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.pc_inc |-> ctl_i.ir_load);

endmodule

// File: rtl/fetch_seq_top.sv
`timescale 1ns/1ps
// Module: fetch_seq_top
// Instruction fetch front end: a three-step fetch through the address and
// data staging registers, plus a data write over the same memory port.
// Assumes: memory returns mem_rdata for mem_addr in time for the edge that
// ends the read strobe cycle, and writes at the edge that ends mem_wr.
module fetch_seq_top
    import fetch_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_go,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] ir_out,
    output logic [AW-1:0] pc_out,
    output logic          fetch_done,
    output logic          wr_done,
    output logic          busy
);

    fs_ctl_t       ctl;
    logic [AW-1:0] mar;
    logic [DW-1:0] mbr;

    fetch_seq_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_go     (fetch_go),
        .wr_req       (wr_req),
        .ctl_o        (ctl),
        .busy_o       (busy),
        .fetch_done_o (fetch_done),
        .wr_done_o    (wr_done)
    );

    fetch_seq_regs #(
        .AW (AW),
        .DW (DW)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rdata_i   (mem_rdata),
        .pc_o      (pc_out),
        .mar_o     (mar),
        .mbr_o     (mbr),
        .ir_o      (ir_out)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = ctl.rd_strobe;
    assign mem_wr    = ctl.wr_strobe;

endmodule

// File: tb/fetch_seq_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for fetch_seq_top: one task per scenario; inputs are driven
// and outputs sampled on the falling edge.
module fetch_seq_top_tb_top;

    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_go;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] ir_out;
    logic [AW-1:0] pc_out;
    logic          fetch_done;
    logic          wr_done;
    logic          busy;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] pc_exp;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    fetch_seq_top #(.AW(AW), .DW(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_go   (fetch_go),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .ir_out     (ir_out),
        .pc_out     (pc_out),
        .fetch_done (fetch_done),
        .wr_done    (wr_done),
        .busy       (busy)
    );

    // Memory model: read data follows the address, writes land at the edge.
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fetch_go = 1'b0; wr_req = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(pc_out == 0, "R1 pc", pc_out, 0);
        chk(mem_addr == 0, "R1 mar", mem_addr, 0);
        chk(mem_wdata == 0, "R1 mbr", mem_wdata, 0);
        chk(ir_out == 0, "R1 ir", ir_out, 0);
        chk(!busy && !mem_rd && !mem_wr && !fetch_done && !wr_done, "R1 flags",
            {busy, mem_rd, mem_wr, fetch_done, wr_done}, 0);
        pc_exp = '0;
    endtask

    // One complete fetch with per-cycle checks.
    task automatic t_fetch();
        logic [DW-1:0] word;
        logic [AW-1:0] nxt;
        nxt = pc_exp + AW'(1);
        @(negedge clk); fetch_go = 1'b1;
        @(negedge clk); fetch_go = 1'b0;
        chk(busy, "R10 busy step1", busy, 1);
        chk(!mem_rd, "R3 no rd step1", mem_rd, 0);
        @(negedge clk);
        chk(mem_rd && !mem_wr, "R3 rd step2", {mem_rd, mem_wr}, 2'b10);
        chk(mem_addr == pc_exp, "R2 mar=pc", mem_addr, pc_exp);
        chk(pc_out == pc_exp, "R5 pc holds", pc_out, pc_exp);
        word = mem[pc_exp];
        @(negedge clk);
        chk(!mem_rd && !fetch_done && busy, "R3 step3", {mem_rd, fetch_done, busy}, 3'b001);
        @(negedge clk);
        chk(fetch_done, "R4 done", fetch_done, 1);
        chk(ir_out == word, "R4 ir word", ir_out, word);
        chk(pc_out == nxt, "R5 pc+1", pc_out, nxt);
        chk(!busy, "R10 idle", busy, 0);
        pc_exp = nxt;
        @(negedge clk);
        chk(!fetch_done, "R4 done one cycle", fetch_done, 0);
    endtask

    task automatic t_fetch_at_50();
        while (pc_exp != AW'(50)) t_fetch();
        chk(pc_out == 50, "R4 start at 50", pc_out, 50);
        t_fetch();
        chk(ir_out == mem[50], "R4 ir from 50", ir_out, mem[50]);
        chk(pc_out == 51, "R5 pc 51", pc_out, 51);
    endtask

    // Plain write, then a fetch of the written word.
    task automatic t_write();
        logic [DW-1:0] val;
        val = 16'hC3A5;
        @(negedge clk); wr_req = 1'b1; wr_addr = pc_exp; wr_data = val;
        @(negedge clk); wr_req = 1'b0;
        chk(busy && !mem_wr, "R6 setup cycle", {busy, mem_wr}, 2'b10);
        @(negedge clk);
        chk(mem_wr && wr_done && !mem_rd, "R6 strobe R7", {mem_wr, wr_done, mem_rd}, 3'b110);
        chk(mem_addr == pc_exp, "R6 addr", mem_addr, pc_exp);
        chk(mem_wdata == val, "R6 data", mem_wdata, val);
        @(negedge clk);
        chk(!mem_wr && !busy, "R6 strobe one cycle", {mem_wr, busy}, 0);
        chk(mem[pc_exp] == val, "R6 stored", mem[pc_exp], val);
        chk(pc_out == pc_exp, "R6 pc unchanged", pc_out, pc_exp);
        t_fetch();
        chk(ir_out == val, "R6 fetched written word", ir_out, val);
    endtask

    // Write raised during a fetch (together=0) or with fetch_go (together=1).
    task automatic t_holdoff(input bit together);
        logic [DW-1:0] word;
        logic [AW-1:0] tgt;
        logic [DW-1:0] val;
        int first_rd;
        int first_wr;
        tgt = pc_exp + AW'(7);
        val = together ? 16'h1B2D : 16'h7E81;
        word = mem[pc_exp];
        first_rd = -1; first_wr = -1;
        @(negedge clk); fetch_go = 1'b1;
        if (together) begin wr_req = 1'b1; wr_addr = tgt; wr_data = val; end
        @(negedge clk); fetch_go = 1'b0;
        if (!together) begin wr_req = 1'b1; wr_addr = tgt; wr_data = val; end
        for (int cyc = 1; cyc <= 8; cyc++) begin
            @(negedge clk);
            chk(!(mem_rd && mem_wr), "R7 exclusive", {mem_rd, mem_wr}, 0);
            if (mem_rd && first_rd < 0) first_rd = cyc;
            if (mem_wr && first_wr < 0) begin
                first_wr = cyc;
                chk(mem_addr == tgt && mem_wdata == val, "R8 write payload", mem_addr, tgt);
                wr_req = 1'b0;
            end
            if (cyc == 3) begin
                chk(fetch_done && ir_out == word, "R8 fetch first", ir_out, word);
            end
        end
        chk(first_rd == 1, "R8 rd cycle", first_rd, 1);
        chk(first_wr == 5, "R8 wr deferred", first_wr, 5);
        chk(mem[tgt] == val, "R8 stored", mem[tgt], val);
        pc_exp = pc_exp + AW'(1);
        chk(pc_out == pc_exp, "R8 pc", pc_out, pc_exp);
    endtask

    // fetch_go held high through the whole fetch.
    task automatic t_go_held();
        int rd_count;
        rd_count = 0;
        @(negedge clk); fetch_go = 1'b1;
        for (int cyc = 0; cyc <= 8; cyc++) begin
            @(negedge clk);
            if (cyc == 3) fetch_go = 1'b0;
            if (mem_rd) rd_count++;
        end
        chk(rd_count == 1, "R9 single read", rd_count, 1);
        pc_exp = pc_exp + AW'(1);
        chk(pc_out == pc_exp, "R9 single step", pc_out, pc_exp);
        chk(!busy, "R9 idle after", busy, 0);
    endtask

    task automatic t_wrap();
        while (pc_exp != {AW{1'b1}}) t_fetch();
        t_fetch();
        chk(pc_out == 0, "R5 wrap to zero", pc_out, 0);
        chk(ir_out == mem[DEPTH-1], "R4 ir at top", ir_out, mem[DEPTH-1]);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 40503 + 7) ^ DW'(i << 3);
        t_reset();
        t_fetch();
        t_fetch_at_50();
        t_write();
        t_holdoff(1'b0);
        t_holdoff(1'b1);
        t_go_held();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule